// File: doc/BRIEF.md
# Bus Transfer-Type Error Monitor

This block sits next to a bus arbiter and inspects the 5-bit transfer-type code presented at the start of each address tenure. Each code falls into one of four classes: ordinary, address-only (an error only when that check is switched on), reserved, or control-word. Ordinary tenures are left to the arbiter. For the three error classes, the block closes the tenure itself. It always pulses the address acknowledge. For control-word codes it then runs a short data phase that ends with a transfer-error pulse.

Every error sets a sticky bit in a status vector. Software clears these bits by writing ones to them. Each status bit can drive one of three outputs: reset request, machine check or ordinary interrupt. A per-class enable bit gates the output, and two per-class routing bits select which one. The transfer type, address and attributes of the first error are held in capture registers. Later errors leave them untouched until software has cleared every status bit.

Top module: `xfer_type_guard`

## Requirements
- R1: Codes 00101, 10110, 00011, 00111 and 01111, and every code with ttype[4]=1 and ttype[0]=1, are reserved (codes written ttype[4:0], MSB first). A reserved code pulses addrAck for exactly one cycle, starting on the cycle after the accepting edge, and sets status[1].
- R2: Codes 10100 and 11100 are control-word errors. They pulse addrAck, then dataStart on the next cycle, then xferErr on the cycle after that, each for one cycle. They set status[2].
- R3: While aoEnable is 1, a code equal to aoCode that is neither reserved nor control-word pulses addrAck and sets status[0]. While aoEnable is 0, such a code is treated as ordinary.
- R4: An ordinary code produces no addrAck, dataStart or xferErr, and it leaves the status unchanged.
- R5: An error tenure holds busy high from its addrAck cycle until its last pulse. A tenureStart that arrives while busy is high is ignored.
- R6: Status bit i drives an output only when maskEn[i] is 1. Within a class, routeRst[i] selects reset request, otherwise routeMcp[i] selects machine check, otherwise the ordinary interrupt is used. Across all classes the priority is resetReq, then machineCheck, then irq, and only the highest active output is asserted.
- R7: While capValid is 0, the first error event loads capType, capAddr and capAttr and sets capValid. Later events do not change these registers.
- R8: Status bits are sticky. A write with clrWe=1 clears the bits set in clrMask. capValid returns to 0 once all status bits are clear, and the next error is captured again.
- R9: When an error event and a clear of the same status bit fall on the same edge, the bit stays set.
- R10: After reset, the status, capValid, all pulse outputs, busy and all three event outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tenureStart | input | 1 | Start of an address tenure; ttype, taddr and tattr are valid |
| ttype | input | 5 | Transfer-type code |
| taddr | input | ADDR_W | Tenure address |
| tattr | input | ATTR_W | Other tenure attributes |
| aoEnable | input | 1 | Treat the address-only code as an error |
| aoCode | input | 5 | Code that identifies an address-only tenure |
| maskEn | input | 3 | Per-class output enable (0 address-only, 1 reserved, 2 control-word) |
| routeRst | input | 3 | Per-class route to reset request |
| routeMcp | input | 3 | Per-class route to machine check |
| clrWe | input | 1 | Write strobe for clearing status |
| clrMask | input | 3 | Status bits to clear |
| addrAck | output | 1 | Address acknowledge pulse |
| dataStart | output | 1 | Data-tenure start pulse |
| xferErr | output | 1 | Transfer-error pulse that ends the data tenure |
| busy | output | 1 | Error tenure in progress; new tenures are refused |
| status | output | 3 | Sticky event status |
| capValid | output | 1 | Capture registers hold a first error |
| capType | output | 5 | Captured transfer type |
| capAddr | output | ADDR_W | Captured address |
| capAttr | output | ATTR_W | Captured attributes |
| resetReq | output | 1 | Reset request |
| machineCheck | output | 1 | Machine-check request |
| irq | output | 1 | Ordinary interrupt |

## Verification
A new error event and a software clear can both target a status bit on the same clock edge. The bench provokes this by driving a reserved-type tenureStart together with clrWe and a mask that includes the reserved bit and the address-only bit. It passes if, after that edge, the reserved bit is still set and the address-only bit is clear. A second collision is a tenureStart held high while a control-word tenure is still running. That tenure is judged refused if its status bit never appears.

// File: rtl/xfer_type_guard_pkg.sv
package xfer_type_guard_pkg;
  localparam int TT_W      = 5;
  localparam int NUM_CLASS = 3;
  localparam int CLS_AO    = 0;
  localparam int CLS_RES   = 1;
  localparam int CLS_CW    = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_ACK, ST_DSTART, ST_TEA} tenureState_t;

  typedef struct packed {
    logic                 logEvent;
    logic [NUM_CLASS-1:0] classVec;
  } guardStrobe_t;

  function automatic logic isControlWord(input logic [TT_W-1:0] code);
    return (code == 5'b10100) || (code == 5'b11100);
  endfunction

  function automatic logic isReserved(input logic [TT_W-1:0] code);
    logic hit;
    hit = (code == 5'b00101) || (code == 5'b10110) || (code == 5'b00011) ||
          (code == 5'b00111) || (code == 5'b01111);
    hit = hit || (code[4] && code[0]);
    return hit;
  endfunction
endpackage

// File: rtl/xfer_type_guard_ctrl.sv
module xfer_type_guard_ctrl
  import xfer_type_guard_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            tenureStart,
  input  logic [TT_W-1:0] ttype,
  input  logic            aoEnable,
  input  logic [TT_W-1:0] aoCode,
  output guardStrobe_t    strobe,
  output logic            addrAck,
  output logic            dataStart,
  output logic            xferErr,
  output logic            busy
);
  tenureState_t         state, stateNext;
  logic                 cwPending;
  logic                 accept;
  logic [NUM_CLASS-1:0] hitVec;

  always_comb begin
    hitVec = '0;
    if (isControlWord(ttype))                hitVec[CLS_CW]  = 1'b1;
    else if (isReserved(ttype))              hitVec[CLS_RES] = 1'b1;
    else if (aoEnable && (ttype == aoCode))  hitVec[CLS_AO]  = 1'b1;
  end

  assign accept          = tenureStart && (state == ST_IDLE);
  assign strobe.logEvent = accept && (|hitVec);
  assign strobe.classVec = hitVec;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (strobe.logEvent) stateNext = ST_ACK;
      ST_ACK:    stateNext = cwPending ? ST_DSTART : ST_IDLE;
      ST_DSTART: stateNext = ST_TEA;
      ST_TEA:    stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cwPending <= 1'b0;
    end else begin
      state <= stateNext;
      if (strobe.logEvent) cwPending <= hitVec[CLS_CW];
    end
  end

  assign addrAck   = (state == ST_ACK);
  assign dataStart = (state == ST_DSTART);
  assign xferErr   = (state == ST_TEA);
  assign busy      = (state != ST_IDLE);
endmodule

// File: rtl/xfer_type_guard_dp.sv
module xfer_type_guard_dp
  import xfer_type_guard_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ATTR_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  guardStrobe_t         strobe,
  input  logic [TT_W-1:0]      ttype,
  input  logic [ADDR_W-1:0]    taddr,
  input  logic [ATTR_W-1:0]    tattr,
  input  logic                 clrWe,
  input  logic [NUM_CLASS-1:0] clrMask,
  input  logic [NUM_CLASS-1:0] maskEn,
  input  logic [NUM_CLASS-1:0] routeRst,
  input  logic [NUM_CLASS-1:0] routeMcp,
  output logic [NUM_CLASS-1:0] status,
  output logic                 capValid,
  output logic [TT_W-1:0]      capType,
  output logic [ADDR_W-1:0]    capAddr,
  output logic [ATTR_W-1:0]    capAttr,
  output logic                 resetReq,
  output logic                 machineCheck,
  output logic                 irq
);
  logic [NUM_CLASS-1:0] statusNext, clrVec, setVec;
  logic                 capLoad, capValidNext;
  logic [NUM_CLASS-1:0] rstHit, mcpHit, irqHit;

  assign clrVec       = clrWe ? clrMask : '0;
  assign setVec       = strobe.logEvent ? strobe.classVec : '0;
  assign statusNext   = (status & ~clrVec) | setVec;
  assign capLoad      = strobe.logEvent && !capValid;
  assign capValidNext = (statusNext == '0) ? 1'b0 : (capValid || capLoad);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      status   <= '0;
      capValid <= 1'b0;
      capType  <= '0;
      capAddr  <= '0;
      capAttr  <= '0;
    end else begin
      status   <= statusNext;
      capValid <= capValidNext;
      if (capLoad) begin
        capType <= ttype;
        capAddr <= taddr;
        capAttr <= tattr;
      end
    end
  end

  for (genvar i = 0; i < NUM_CLASS; i++) begin : g_route
    logic active;
    assign active    = status[i] && maskEn[i];
    assign rstHit[i] = active && routeRst[i];
    assign mcpHit[i] = active && !routeRst[i] && routeMcp[i];
    assign irqHit[i] = active && !routeRst[i] && !routeMcp[i];
  end

  assign resetReq     = |rstHit;
  assign machineCheck = !resetReq && (|mcpHit);
  assign irq          = !resetReq && !(|mcpHit) && (|irqHit);
endmodule

// File: rtl/xfer_type_guard.sv
module xfer_type_guard
  import xfer_type_guard_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ATTR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tenureStart,
  input  logic [4:0]        ttype,
  input  logic [ADDR_W-1:0] taddr,
  input  logic [ATTR_W-1:0] tattr,
  input  logic              aoEnable,
  input  logic [4:0]        aoCode,
  input  logic [2:0]        maskEn,
  input  logic [2:0]        routeRst,
  input  logic [2:0]        routeMcp,
  input  logic              clrWe,
  input  logic [2:0]        clrMask,
  output logic              addrAck,
  output logic              dataStart,
  output logic              xferErr,
  output logic              busy,
  output logic [2:0]        status,
  output logic              capValid,
  output logic [4:0]        capType,
  output logic [ADDR_W-1:0] capAddr,
  output logic [ATTR_W-1:0] capAttr,
  output logic              resetReq,
  output logic              machineCheck,
  output logic              irq
);
  guardStrobe_t strobe;

  xfer_type_guard_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .tenureStart(tenureStart), .ttype(ttype),
    .aoEnable(aoEnable), .aoCode(aoCode), .strobe(strobe),
    .addrAck(addrAck), .dataStart(dataStart), .xferErr(xferErr), .busy(busy)
  );

  xfer_type_guard_dp #(.ADDR_W(ADDR_W), .ATTR_W(ATTR_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ttype(ttype), .taddr(taddr),
    .tattr(tattr), .clrWe(clrWe), .clrMask(clrMask), .maskEn(maskEn),
    .routeRst(routeRst), .routeMcp(routeMcp), .status(status),
    .capValid(capValid), .capType(capType), .capAddr(capAddr),
    .capAttr(capAttr), .resetReq(resetReq), .machineCheck(machineCheck),
    .irq(irq)
  );
endmodule

// File: rtl/xfer_type_guard_chk.sv
module xfer_type_guard_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              tenureStart,
  input logic              busy,
  input logic              addrAck,
  input logic              dataStart,
  input logic              xferErr,
  input logic [2:0]        status,
  input logic              clrWe,
  input logic              capValid,
  input logic [ADDR_W-1:0] capAddr,
  input logic              resetReq,
  input logic              machineCheck,
  input logic              irq
);
  assert_ack_single_R1: assert property (@(posedge clk) disable iff (!rstN)
    addrAck |=> !addrAck);

  assert_dstart_after_ack_R2: assert property (@(posedge clk) disable iff (!rstN)
    dataStart |-> $past(addrAck));

  assert_tea_after_dstart_R2: assert property (@(posedge clk) disable iff (!rstN)
    xferErr |-> $past(dataStart));

  assert_ack_needs_accept_R5: assert property (@(posedge clk) disable iff (!rstN)
    addrAck |-> ($past(tenureStart) && !$past(busy)));

  assert_one_route_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({resetReq, machineCheck, irq}));

  assert_capture_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (capValid && $past(capValid)) |-> $stable(capAddr));

  assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$past(clrWe) |-> ((status & $past(status)) == $past(status)));
endmodule

bind xfer_type_guard xfer_type_guard_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rstN(rstN), .tenureStart(tenureStart), .busy(busy),
  .addrAck(addrAck), .dataStart(dataStart), .xferErr(xferErr),
  .status(status), .clrWe(clrWe), .capValid(capValid), .capAddr(capAddr),
  .resetReq(resetReq), .machineCheck(machineCheck), .irq(irq)
);

// File: tb/test_xfer_type_guard.sv
module test_xfer_type_guard;
  localparam int ADDR_W = 32;
  localparam int ATTR_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic              tenureStart = 1'b0;
  logic [4:0]        ttype = '0;
  logic [ADDR_W-1:0] taddr = '0;
  logic [ATTR_W-1:0] tattr = '0;
  logic              aoEnable = 1'b0;
  logic [4:0]        aoCode = '0;
  logic [2:0]        maskEn = '0, routeRst = '0, routeMcp = '0;
  logic              clrWe = 1'b0;
  logic [2:0]        clrMask = '0;
  logic addrAck, dataStart, xferErr, busy, capValid, resetReq, machineCheck, irq;
  logic [2:0]        status;
  logic [4:0]        capType;
  logic [ADDR_W-1:0] capAddr;
  logic [ATTR_W-1:0] capAttr;

  int nChecks = 0;
  int nFails  = 0;

  xfer_type_guard #(.ADDR_W(ADDR_W), .ATTR_W(ATTR_W)) i_xfer_type_guard (.*);

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // 0 ordinary, 2 reserved, 3 control-word (per R1, R2)
  function automatic int expClass(input logic [4:0] c);
    if (c == 5'b10100 || c == 5'b11100) return 3;
    if (c == 5'b00101 || c == 5'b10110 || c == 5'b00011 ||
        c == 5'b00111 || c == 5'b01111) return 2;
    if (c[4] && c[1:0] == 2'b01) return 2;
    if (c[4] && c[1:0] == 2'b11) return 2;
    return 0;
  endfunction

  task automatic issue(input logic [4:0] code, input logic [ADDR_W-1:0] a,
                       input logic [ATTR_W-1:0] at);
    @(negedge clk);
    tenureStart = 1'b1; ttype = code; taddr = a; tattr = at;
    @(negedge clk);
    tenureStart = 1'b0;
  endtask

  task automatic clearBits(input logic [2:0] m);
    @(negedge clk);
    clrWe = 1'b1; clrMask = m;
    @(negedge clk);
    clrWe = 1'b0; clrMask = '0;
  endtask

  task automatic waitIdle();
    repeat (4) @(negedge clk);
  endtask

  task automatic testReset();
    check("R10", "status", status, 0);
    check("R10", "capValid", capValid, 0);
    check("R10", "pulses", {addrAck, dataStart, xferErr, busy}, 0);
    check("R10", "events", {resetReq, machineCheck, irq}, 0);
  endtask

  task automatic runCode(input logic [4:0] code);
    int cls;
    string tag;
    cls = expClass(code);
    tag = (cls == 3) ? "R2" : (cls == 2) ? "R1" : "R4";
    issue(code, {27'h0, code}, 8'h5A);
    check(tag, $sformatf("addrAck code %b", code), addrAck, cls != 0);
    check(tag, $sformatf("status code %b", code), status,
          (cls == 3) ? 3'b100 : (cls == 2) ? 3'b010 : 3'b000);
    @(negedge clk);
    check(tag, $sformatf("addrAck one cycle %b", code), addrAck, 0);
    check(tag, $sformatf("dataStart code %b", code), dataStart, cls == 3);
    @(negedge clk);
    check(tag, $sformatf("xferErr code %b", code), xferErr, cls == 3);
    @(negedge clk);
    check(tag, $sformatf("idle code %b", code), {busy, xferErr}, 0);
    clearBits(3'b111);
  endtask

  task automatic testSweep();
    for (int c = 0; c < 32; c++) runCode(c[4:0]);
  endtask

  task automatic testAddrOnly();
    aoCode = 5'b01010;
    aoEnable = 1'b0;
    issue(5'b01010, 32'h100, 8'h1);
    check("R3", "disabled ack", addrAck, 0);
    check("R3", "disabled status", status, 0);
    waitIdle();
    aoEnable = 1'b1;
    issue(5'b01011, 32'h104, 8'h1);
    check("R3", "other code ack", addrAck, 0);
    waitIdle();
    issue(5'b01010, 32'h108, 8'h1);
    check("R3", "enabled ack", addrAck, 1);
    check("R3", "enabled status", status, 3'b001);
    @(negedge clk);
    check("R3", "no data phase", {addrAck, dataStart, busy}, 0);
    aoEnable = 1'b0;
    clearBits(3'b111);
  endtask

  task automatic testBusy();
    @(negedge clk);
    tenureStart = 1'b1; ttype = 5'b10100; taddr = 32'h200;
    @(negedge clk);
    ttype = 5'b00101;
    check("R5", "busy in ack", busy, 1);
    @(negedge clk);
    check("R5", "busy in data start", {busy, dataStart}, 2'b11);
    @(negedge clk);
    check("R5", "busy in xferErr", {busy, xferErr}, 2'b11);
    tenureStart = 1'b0;
    @(negedge clk);
    check("R5", "idle after tenure", {busy, addrAck}, 0);
    check("R5", "held start ignored", status, 3'b100);
    clearBits(3'b111);
  endtask

  task automatic route(input logic [2:0] m, input logic [2:0] r, input logic [2:0] mc,
                       input logic [2:0] exp, input string what);
    @(negedge clk);
    maskEn = m; routeRst = r; routeMcp = mc;
    #1;
    check("R6", what, {resetReq, machineCheck, irq}, exp);
  endtask

  task automatic testRouting();
    aoCode = 5'b01010; aoEnable = 1'b1;
    issue(5'b01010, 32'h300, 8'h0); waitIdle();
    issue(5'b00101, 32'h304, 8'h0); waitIdle();
    issue(5'b11100, 32'h308, 8'h0); waitIdle();
    aoEnable = 1'b0;
    check("R6", "all classes logged", status, 3'b111);
    route(3'b000, 3'b111, 3'b111, 3'b000, "all masked");
    route(3'b010, 3'b000, 3'b000, 3'b001, "irq only");
    route(3'b010, 3'b000, 3'b010, 3'b010, "mcp only");
    route(3'b010, 3'b010, 3'b010, 3'b100, "rst beats mcp in class");
    route(3'b111, 3'b100, 3'b001, 3'b100, "rst beats mcp across");
    route(3'b011, 3'b100, 3'b001, 3'b010, "masked rst class");
    route(3'b010, 3'b100, 3'b001, 3'b001, "irq when others masked");
    route(3'b000, 3'b000, 3'b000, 3'b000, "restore");
    clearBits(3'b111);
  endtask

  task automatic testCapture();
    check("R8", "capValid after clear", capValid, 0);
    issue(5'b00101, 32'hA000_0001, 8'h11); waitIdle();
    issue(5'b10100, 32'hA000_0002, 8'h22); waitIdle();
    check("R7", "capValid", capValid, 1);
    check("R7", "capAddr first", capAddr, 32'hA000_0001);
    check("R7", "capAttr first", capAttr, 8'h11);
    check("R7", "capType first", capType, 5'b00101);
    clearBits(3'b010);
    check("R8", "partial clear status", status, 3'b100);
    check("R8", "capValid held", capValid, 1);
    clearBits(3'b100);
    check("R8", "full clear status", status, 0);
    check("R8", "capValid reopened", capValid, 0);
    issue(5'b10110, 32'hA000_0003, 8'h33); waitIdle();
    check("R8", "recapture addr", capAddr, 32'hA000_0003);
    check("R8", "recapture type", capType, 5'b10110);
    clearBits(3'b111);
  endtask

  task automatic testClearRace();
    aoCode = 5'b01010; aoEnable = 1'b1;
    issue(5'b01010, 32'h400, 8'h0); waitIdle();
    issue(5'b00101, 32'h404, 8'h0); waitIdle();
    check("R9", "setup status", status, 3'b011);
    @(negedge clk);
    tenureStart = 1'b1; ttype = 5'b00101; clrWe = 1'b1; clrMask = 3'b011;
    @(negedge clk);
    tenureStart = 1'b0; clrWe = 1'b0; clrMask = '0;
    check("R9", "event beats clear", status, 3'b010);
    check("R9", "ack on race", addrAck, 1);
    aoEnable = 1'b0;
    waitIdle();
    clearBits(3'b111);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSweep();
    testAddrOnly();
    testBusy();
    testRouting();
    testCapture();
    testClearRace();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule